// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM with Selectable Deselect Depth

This block is a single-port synchronous memory with a registered read path and a byte-maskable write path. It is organised as lanes of nine bits. Depth and lane count are parameters, so the full-size array can be scaled down for simulation. Every access is begun by one of two address strobes. The first strobe always starts a read. The second strobe starts either a read or a write, as decided by the write controls. Once a burst is open, later cycles advance through a four-beat sequence, in linear or interleaved order, or hold the current address. The data bus is shown as a data vector plus a drive-enable. The drive-enable is gated asynchronously by an output enable and by the sleep input.

A four-state machine tracks the bus. The states are `ST_IDLE` (deselected), `ST_READ` (burst open for reads), `ST_WRITE` (burst open for writes) and `ST_SLEEP` (standby). Each cycle is decoded into one of five commands: `CMD_NOP`, `CMD_DESEL`, `CMD_START`, `CMD_NEXT` and `CMD_HOLD`. The transitions are:
- Any state goes to `ST_SLEEP` while sleep is high.
- `CMD_DESEL` goes to `ST_IDLE`.
- `CMD_START`, `CMD_NEXT` and `CMD_HOLD` go to `ST_WRITE` or `ST_READ`, according to the decoded operation.
- `CMD_NOP` leaves `ST_SLEEP` for `ST_IDLE` and keeps any other state.

`CMD_NEXT` and `CMD_HOLD` are decoded only from `ST_READ` and `ST_WRITE`. In other states, both strobes high gives `CMD_NOP`.

A read captured at clock edge k loads the array output register at edge k+1, and that data is driven after edge k+1. Each later beat of the burst follows one clock behind its command. With `desel_early` high, a deselect turns the drivers off right after the edge that captures it. With `desel_early` low, data already in flight is still driven for one more cycle.

Top module: `pburst_sram`

## Requirements
- R1: The chip is enabled when `en1_n`=0, `en2`=1 and `en3_n`=0. If the chip is enabled and `strobe_cpu_n`=0, the cycle starts a read burst at `addr`, whatever the write inputs say. The word at `addr` is driven after the next rising edge, with `rdata_oe`=1.
- R2: If the chip is enabled, `strobe_cpu_n`=1 and `strobe_ctl_n`=0, the cycle starts a burst at `addr`. It is a write when the write decode of R6 is true, and a read otherwise.
- R3: With both strobes high, an open burst, and `advance_n`=0, the access moves to the next address of the burst. The low two address bits follow the sequence, and the upper bits keep the value from the start of the burst.
- R4: If `burst_linear`=1, the burst offset is (start + n) mod 4. If `burst_linear`=0, it is start XOR n. Here n counts advances modulo 4, so the fifth beat returns to the start address.
- R5: With both strobes high, an open burst, and `advance_n`=1, the access repeats at the current address, as a read or a write.
- R6: If `wr_all_n`=0, all lanes are written. Otherwise, if `wr_byte_n`=0 and some bit of `lane_n` is 0, the lanes i with `lane_n[i]`=0 are written. Lane i is `wdata[9i+8:9i]`. Any other combination is a read.
- R7: A write command turns `rdata_oe` off from its own edge onward, and any read data already in flight is dropped. During reads, all lanes are driven whatever `lane_n` says.
- R8: If `desel_early`=1, a deselect (chip disabled and `strobe_ctl_n`=0) forces `rdata_oe` to 0 right after the edge that captures it.
- R9: If `desel_early`=0, read data pending at a deselect is still driven for one cycle after the deselect edge, and is off after the following edge.
- R10: `rdata_oe` is 1 only while `out_en_n`=0. Raising `out_en_n` turns the drive off at once, with no clock edge.
- R11: While `sleep`=1, `rdata_oe` is 0 and commands are ignored. The burst closes, and the stored contents are retained for later reads.
- R12: When the chip is disabled, `strobe_cpu_n`=0 is ignored. With `strobe_ctl_n`=1, the cycle behaves as a continue or hold of an open burst, and as a no-op when no burst is open.
- R13: Write data is stored at the edge of its command. A read of the same address on the next cycle returns the new data.
- R14: After reset, `rdata_oe` is 0 and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| en1_n | input | 1 | Chip enable, active low |
| en2 | input | 1 | Chip enable, active high |
| en3_n | input | 1 | Chip enable, active low |
| strobe_cpu_n | input | 1 | Read-start address strobe, active low |
| strobe_ctl_n | input | 1 | Read/write-start address strobe, active low |
| advance_n | input | 1 | Burst advance when low, hold when high |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Lane-selective write enable, active low |
| lane_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Standby request, active high |
| desel_early | input | 1 | 1 = single-cycle deselect, 0 = dual-cycle deselect |
| burst_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data |
| rdata_oe | output | 1 | Read data drive enable |

## Verification
The hardest situations to reach are those where a deselect, a write or sleep arrives while read data is still in flight between the address stage and the output register. They are also the ones where the two deselect depths differ. The stimulus reaches them by starting a read and issuing the deselect, write or sleep on the very next edge, once with `desel_early` high and once low. It also opens a burst and then disables the chip while the read-start strobe is low, so the ignored strobe falls through to a continue. A behavioural model in the bench keeps a memory image, the burst position and the pending read. It predicts `rdata_oe` and `rdata` for every clock.

// File: rtl/pbs_pkg.sv
`timescale 1ns/1ps
package pbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_SLEEP
    } pbs_state_t;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_DESEL,
        CMD_START,
        CMD_NEXT,
        CMD_HOLD
    } pbs_cmd_t;
endpackage

// File: rtl/pbs_burst.sv
`timescale 1ns/1ps
module pbs_burst #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] start,
    input  logic             linear,
    output logic [CNT_W-1:0] cur,
    output logic [CNT_W-1:0] nxt
);
    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    function automatic logic [CNT_W-1:0] order_of(input logic [CNT_W-1:0] b,
                                                  input logic [CNT_W-1:0] c,
                                                  input logic lin);
        logic [CNT_W-1:0] r;
        if (lin) r = b + c;
        else     r = b ^ c;
        return r;
    endfunction

    assign cnt_inc = cnt_q + CNT_W'(1);
    assign cur     = order_of(base_q, cnt_q, linear);
    assign nxt     = order_of(base_q, cnt_inc, linear);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= start;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_inc;
        end
    end

    // R3: a freshly loaded burst presents its start offset as the current beat
    p_first_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur == $past(start)));
endmodule

// File: rtl/pbs_array.sv
`timescale 1ns/1ps
module pbs_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g]) store[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            if (rd_en) q <= store[rd_addr];
        end

        assign rd_data[g*LANE_W +: LANE_W] = q;
    end
endmodule

// File: rtl/pbs_ctrl.sv
`timescale 1ns/1ps
module pbs_ctrl
    import pbs_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en1_n,
    input  logic               en2,
    input  logic               en3_n,
    input  logic               strobe_cpu_n,
    input  logic               strobe_ctl_n,
    input  logic               advance_n,
    input  logic               wr_all_n,
    input  logic               wr_byte_n,
    input  logic [LANES-1:0]   lane_n,
    input  logic               sleep,
    input  logic               desel_early,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BURST_W-1:0] beat_cur,
    input  logic [BURST_W-1:0] beat_nxt,
    output logic               burst_load,
    output logic               burst_step,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  acc_addr,
    output logic [LANES-1:0]   wr_mask,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic               drive_q
);
    localparam int HI_W = ADDR_W - BURST_W;

    pbs_state_t        state_q, state_d;
    pbs_cmd_t          cmd;
    logic              chip_on;
    logic              wr_dec;
    logic              op_wr;
    logic              rd_req;
    logic              kill;
    logic [HI_W-1:0]   hi_q;
    logic              s1_rd;
    logic [ADDR_W-1:0] s1_addr;

    assign chip_on = !en1_n && en2 && !en3_n;
    assign wr_dec  = !wr_all_n || (!wr_byte_n && !(&lane_n));
    assign wr_mask = !wr_all_n ? {LANES{1'b1}} : ~lane_n;

    // Command decode: a disabled chip ignores the read-start strobe
    always_comb begin
        cmd   = CMD_NOP;
        op_wr = 1'b0;
        if (!chip_on && !strobe_ctl_n) begin
            cmd = CMD_DESEL;
        end else if (chip_on && !strobe_cpu_n) begin
            cmd = CMD_START;
        end else if (chip_on && !strobe_ctl_n) begin
            cmd   = CMD_START;
            op_wr = wr_dec;
        end else if (state_q == ST_READ || state_q == ST_WRITE) begin
            cmd   = advance_n ? CMD_HOLD : CMD_NEXT;
            op_wr = wr_dec;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (sleep) begin
            state_d = ST_SLEEP;
        end else begin
            unique case (cmd)
                CMD_DESEL: state_d = ST_IDLE;
                CMD_START,
                CMD_NEXT,
                CMD_HOLD:  state_d = op_wr ? ST_WRITE : ST_READ;
                default:   state_d = (state_q == ST_SLEEP) ? ST_IDLE : state_q;
            endcase
        end
    end

    // Outputs of the current cycle
    always_comb begin
        burst_load = 1'b0;
        burst_step = 1'b0;
        acc_addr   = addr;
        unique case (cmd)
            CMD_START: burst_load = !sleep;
            CMD_NEXT: begin
                burst_step = !sleep;
                acc_addr   = {hi_q, beat_nxt};
            end
            CMD_HOLD:  acc_addr = {hi_q, beat_cur};
            default:   acc_addr = addr;
        endcase
        wr_en  = !sleep && op_wr && (cmd inside {CMD_START, CMD_NEXT, CMD_HOLD});
        rd_req = !sleep && !op_wr && (cmd inside {CMD_START, CMD_NEXT, CMD_HOLD});
        kill   = sleep || wr_en || (cmd == CMD_DESEL && desel_early);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Read pipeline and burst upper address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            s1_rd   <= 1'b0;
            s1_addr <= '0;
            drive_q <= 1'b0;
        end else begin
            if (burst_load) hi_q <= addr[ADDR_W-1:BURST_W];
            s1_rd   <= rd_req;
            if (rd_req) s1_addr <= acc_addr;
            drive_q <= s1_rd && !kill;
        end
    end

    assign rd_en   = s1_rd;
    assign rd_addr = s1_addr;

    // R1: drive only ever starts from a read that was in flight
    p_drive_from_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_q) |-> $past(s1_rd));
    // R7: a write leaves the bus undriven in the following cycle
    p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !drive_q);
    // R8: early deselect releases the bus at once
    p_early_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_DESEL && desel_early) |=> !drive_q);
    // R9: late deselect still shows pending data for one cycle
    p_late_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_DESEL && !desel_early && !sleep && s1_rd) |=> drive_q ##1 !drive_q);
    // R11: sleep empties the pipeline
    p_sleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (state_q == ST_SLEEP && !drive_q && !s1_rd));
    // R12: a disabled chip never opens a burst
    p_ignore_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_on |-> !burst_load);
    // R6: never a read and a write in the same cycle
    p_one_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, rd_req}));
endmodule

// File: rtl/pburst_sram.sv
`timescale 1ns/1ps
module pburst_sram #(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en1_n,
    input  logic                    en2,
    input  logic                    en3_n,
    input  logic                    strobe_cpu_n,
    input  logic                    strobe_ctl_n,
    input  logic                    advance_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    out_en_n,
    input  logic                    sleep,
    input  logic                    desel_early,
    input  logic                    burst_linear,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);
    logic               burst_load;
    logic               burst_step;
    logic [BURST_W-1:0] beat_cur;
    logic [BURST_W-1:0] beat_nxt;
    logic               wr_en;
    logic [ADDR_W-1:0]  acc_addr;
    logic [LANES-1:0]   wr_mask;
    logic               rd_en;
    logic [ADDR_W-1:0]  rd_addr;
    logic               drive_q;

    pbs_burst #(.CNT_W(BURST_W)) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (burst_load),
        .step   (burst_step),
        .start  (addr[BURST_W-1:0]),
        .linear (burst_linear),
        .cur    (beat_cur),
        .nxt    (beat_nxt)
    );

    pbs_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .en1_n        (en1_n),
        .en2          (en2),
        .en3_n        (en3_n),
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .advance_n    (advance_n),
        .wr_all_n     (wr_all_n),
        .wr_byte_n    (wr_byte_n),
        .lane_n       (lane_n),
        .sleep        (sleep),
        .desel_early  (desel_early),
        .addr         (addr),
        .beat_cur     (beat_cur),
        .beat_nxt     (beat_nxt),
        .burst_load   (burst_load),
        .burst_step   (burst_step),
        .wr_en        (wr_en),
        .acc_addr     (acc_addr),
        .wr_mask      (wr_mask),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .drive_q      (drive_q)
    );

    pbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (acc_addr),
        .wr_mask (wr_mask),
        .wr_data (wdata),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rdata)
    );

    assign rdata_oe = drive_q && !out_en_n && !sleep;

    // R10: a high output enable input always wins over the pipeline
    p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rdata_oe);
    // R11: no drive while in standby
    p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rdata_oe);
endmodule

// File: tb/pburst_sram_test.sv
`timescale 1ns/1ps
module pburst_sram_test;
    localparam int AW = 8;
    localparam int NL = 4;
    localparam int DW = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en1_n = 1'b1, en2 = 1'b1, en3_n = 1'b0;
    logic strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, advance_n = 1'b1;
    logic wr_all_n = 1'b1, wr_byte_n = 1'b1;
    logic [NL-1:0] lane_n = '1;
    logic out_en_n = 1'b0, sleep = 1'b0, desel_early = 1'b1, burst_linear = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rdata_oe;

    int errs = 0;
    int checks = 0;
    bit done = 0;
    string cur_req = "R14";

    // reference model state
    logic [DW-1:0] mmem [1<<AW];
    bit            m_act = 0;
    logic [1:0]    m_base = '0;
    int            m_cnt = 0;
    logic [AW-3:0] m_hi = '0;
    bit            p_val = 0;
    logic [AW-1:0] p_addr = '0;
    bit            o_drv = 0;
    logic [DW-1:0] o_dat = '0;

    always #2.5 clk = ~clk;

    pburst_sram uut (
        .clk(clk), .rst_n(rst_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .advance_n(advance_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n), .out_en_n(out_en_n),
        .sleep(sleep), .desel_early(desel_early), .burst_linear(burst_linear),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] seq(input logic [1:0] b, input int c);
        logic [1:0] cc;
        cc = c[1:0];
        return burst_linear ? (b + cc) : (b ^ cc);
    endfunction

    task automatic model_edge();
        bit on, wdec, w, kill;
        logic [NL-1:0] mk;
        int cmd;
        logic [AW-1:0] ea;
        on   = !en1_n && en2 && !en3_n;
        wdec = !wr_all_n || (!wr_byte_n && lane_n != '1);
        mk   = !wr_all_n ? '1 : ~lane_n;
        w = 0;
        ea = addr;
        if (sleep) begin
            o_drv = 0; p_val = 0; m_act = 0;
            return;
        end
        if (!on && !strobe_ctl_n) cmd = 1;
        else if (on && !strobe_cpu_n) cmd = 2;
        else if (on && !strobe_ctl_n) begin cmd = 2; w = wdec; end
        else if (m_act) begin cmd = advance_n ? 4 : 3; w = wdec; end
        else cmd = 0;
        if (cmd == 3) ea = {m_hi, seq(m_base, m_cnt + 1)};
        if (cmd == 4) ea = {m_hi, seq(m_base, m_cnt)};
        kill = (cmd >= 2 && w) || (cmd == 1 && desel_early);
        if (p_val) o_dat = mmem[p_addr];
        o_drv = p_val && !kill;
        if (cmd >= 2 && w)
            for (int i = 0; i < NL; i++)
                if (mk[i]) mmem[ea][i*9 +: 9] = wdata[i*9 +: 9];
        p_val = (cmd >= 2) && !w;
        p_addr = ea;
        if (cmd == 1) m_act = 0;
        if (cmd == 2) begin m_act = 1; m_base = addr[1:0]; m_cnt = 0; m_hi = addr[AW-1:2]; end
        if (cmd == 3) m_cnt++;
    endtask

    task automatic tick();
        bit eo;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        eo = o_drv && !out_en_n && !sleep;
        check(cur_req, "drive", DW'(rdata_oe), DW'(eo));
        if (eo) check(cur_req, "data", rdata, o_dat);
    endtask

    task automatic quiet();
        en1_n = 0; en2 = 1; en3_n = 0;
        strobe_cpu_n = 1; strobe_ctl_n = 1; advance_n = 1;
        wr_all_n = 1; wr_byte_n = 1; lane_n = '1; sleep = 0;
    endtask

    task automatic rd_cpu(input logic [AW-1:0] a);
        quiet(); strobe_cpu_n = 0; addr = a; tick();
    endtask

    task automatic start_ctl(input logic [AW-1:0] a, input logic ga, input logic gb,
                             input logic [NL-1:0] ln, input logic [DW-1:0] d);
        quiet(); strobe_ctl_n = 0; addr = a; wr_all_n = ga; wr_byte_n = gb;
        lane_n = ln; wdata = d; tick();
    endtask

    task automatic cont(input logic adv, input logic ga, input logic gb,
                        input logic [NL-1:0] ln, input logic [DW-1:0] d);
        quiet(); advance_n = adv; wr_all_n = ga; wr_byte_n = gb; lane_n = ln;
        wdata = d; addr = ~addr; tick();
    endtask

    task automatic desel();
        quiet(); en1_n = 1; strobe_ctl_n = 0; tick();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R14";
        check(cur_req, "reset drive", DW'(rdata_oe), '0);
        rst_n = 1;
        quiet(); en1_n = 1;
        tick();

        // R2/R6: controller strobe starts a global write burst, then lanes
        cur_req = "R2";
        start_ctl(8'h10, 0, 1, '1, 36'h1_1111_1111);
        cur_req = "R3";
        cont(0, 0, 1, '1, 36'h2_2222_2222);
        cont(0, 0, 1, '1, 36'h3_3333_3333);
        cont(0, 0, 1, '1, 36'h4_4444_4444);
        cur_req = "R6";
        start_ctl(8'h20, 0, 1, '1, 36'hA_AAAA_AAAA);
        start_ctl(8'h20, 1, 0, 4'b1010, 36'h5_5555_5555);
        start_ctl(8'h20, 1, 0, 4'b1111, 36'hF_0F0F_0F0F);
        start_ctl(8'h21, 1, 1, 4'b0000, 36'h7_7777_7777);
        cont(1, 1, 1, '1, '0);
        cont(1, 1, 1, '1, '0);

        // R1: processor strobe reads even with write inputs active
        cur_req = "R1";
        quiet(); strobe_cpu_n = 0; addr = 8'h10; wr_all_n = 0; wdata = '1; tick();
        cur_req = "R3";
        cont(0, 1, 1, '1, '0);
        cont(0, 1, 1, '1, '0);
        cont(0, 1, 1, '1, '0);
        cur_req = "R4";
        cont(0, 1, 1, '1, '0);
        cont(1, 1, 1, '1, '0);

        // R4: interleaved order from offset 2
        burst_linear = 0;
        rd_cpu(8'h12);
        cont(0, 1, 1, '1, '0);
        cont(0, 1, 1, '1, '0);
        cont(0, 1, 1, '1, '0);
        cont(0, 1, 1, '1, '0);
        burst_linear = 1;

        // R5: suspend keeps the address
        cur_req = "R5";
        rd_cpu(8'h11);
        cont(1, 1, 1, '1, '0);
        cont(1, 1, 1, '1, '0);
        start_ctl(8'h30, 0, 1, '1, 36'h3_0303_0303);
        cont(1, 0, 1, '1, 36'h3_1313_1313);
        rd_cpu(8'h30);
        cont(1, 1, 1, '1, '0);

        // R10: asynchronous output enable
        cur_req = "R10";
        out_en_n = 1; #1;
        check("R10", "async off", DW'(rdata_oe), '0);
        out_en_n = 0; #1;
        check("R10", "async on", DW'(rdata_oe), DW'(1));
        cont(1, 1, 1, '1, '0);

        // R8: early deselect right behind a read
        cur_req = "R8";
        desel_early = 1;
        rd_cpu(8'h20);
        desel();
        desel();

        // R9: late deselect keeps pending data one cycle
        cur_req = "R9";
        desel_early = 0;
        rd_cpu(8'h13);
        desel();
        desel();
        desel_early = 1;

        // R7: write right behind read drops in-flight data
        cur_req = "R7";
        rd_cpu(8'h10);
        start_ctl(8'h40, 0, 1, '1, 36'h4_0404_0404);
        rd_cpu(8'h21);
        cont(1, 1, 1, '1, '0);

        // R13: read-after-write to the same address
        cur_req = "R13";
        start_ctl(8'h50, 0, 1, '1, 36'h5_0505_0505);
        rd_cpu(8'h50);
        cont(1, 1, 1, '1, '0);

        // R12: disabled chip, processor strobe ignored
        cur_req = "R12";
        rd_cpu(8'h10);
        quiet(); en1_n = 1; strobe_cpu_n = 0; advance_n = 0; addr = 8'h40; tick();
        quiet(); en1_n = 1; strobe_cpu_n = 0; advance_n = 1; addr = 8'h50; tick();
        desel();
        quiet(); en1_n = 1; strobe_cpu_n = 0; addr = 8'h50; tick();
        quiet(); en2 = 0; strobe_cpu_n = 0; addr = 8'h50; tick();

        // R11: sleep in the middle of a burst, contents retained
        cur_req = "R11";
        rd_cpu(8'h30);
        quiet(); sleep = 1; strobe_ctl_n = 0; addr = 8'h30; wr_all_n = 0;
        wdata = 36'hD_EADD_EADD; tick();
        quiet(); sleep = 1; tick();
        quiet(); tick();
        rd_cpu(8'h30);
        cont(0, 1, 1, '1, '0);
        cont(1, 1, 1, '1, '0);

        done = 1;
        finish_run();
    end
endmodule